// File: doc/BRIEF.md
# Register Scoreboard Wakeup Tracker

This block holds one ready bit per physical register and records which issue-queue slots are waiting on each register that is not yet ready. When an instruction is placed into a slot, it supplies up to two source registers and one destination register. Each source may carry a hint that it is already known to be ready. A source with no such hint is checked against the scoreboard. If the register is not ready, the slot is added to that register's waiter set. The destination register is then marked not ready, and the dispatching slot is recorded as the register's producer.

When a destination register completes, every slot waiting on it has its matching sources marked ready in the same step. The waiter set and the producer record are then cleared, and the scoreboard bit is set. In the same cycle the block reports how many slots were woken and which slot produced the register. A squash port frees a slot and removes it from the waiter sets of those of its sources that were still unready. Register indices at or above the physical register count are never tracked.

Per-slot ready flags go to an issue selector, which sits outside this block.

Top module: `reg_wakeup_tracker`

## Requirements
- R1: After reset, every bit of `reg_ready_o` and `slot_ready_o` is 0.
- R2: A dispatch with a tracked destination clears that register's ready bit from the next cycle on, and records the slot as producer. A later completion of the register then shows `cmpl_prod_vld_o`=1 with `cmpl_prod_o` equal to that slot, in the completion cycle.
- R3: `conflict_o` is 1, in the same cycle, when a dispatch names a tracked destination whose waiter set is not empty. A completion of that same register in that cycle empties the set first, so no conflict is flagged.
- R4: A valid source is ready at dispatch when any of the following holds: its hint is 1, its scoreboard bit is 1, or a completion of that register occurs in the same cycle. Any other valid source makes the slot wait on that register. A source whose valid bit is 0 counts as ready.
- R5: A completion of a tracked register sets its ready bit from the next cycle on. It also marks ready, from the next cycle on, every unready source of every waiting slot that names that register.
- R6: `wake_count_o` equals, in the completion cycle, the number of slots in the completed register's waiter set.
- R7: Register indices at or above NUM_PREGS are untracked. As sources they count as ready. As destinations they change no state. A completion of such an index wakes nothing, reports a count of 0 and has `cmpl_prod_vld_o`=0.
- R8: A squash clears the slot's ready flag from the next cycle on and removes the slot from its unready sources' waiter sets. Completions after that do not count the slot.
- R9: `slot_ready_o[s]` is 1 exactly when slot s is occupied and both of its sources are ready.
- R10: When a dispatch destination and a completion name the same register in one cycle, the completion takes effect first. The register ends not ready, with the new slot as its producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch strobe |
| disp_slot_i | input | SLOT_W | Queue slot being filled |
| disp_src0_valid_i | input | 1 | Source 0 present |
| disp_src0_i | input | REG_IDX_W | Source 0 register |
| disp_src0_rdy_i | input | 1 | Source 0 known ready |
| disp_src1_valid_i | input | 1 | Source 1 present |
| disp_src1_i | input | REG_IDX_W | Source 1 register |
| disp_src1_rdy_i | input | 1 | Source 1 known ready |
| disp_dst_valid_i | input | 1 | Destination present |
| disp_dst_i | input | REG_IDX_W | Destination register |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_reg_i | input | REG_IDX_W | Completed register |
| squash_valid_i | input | 1 | Squash strobe |
| squash_slot_i | input | SLOT_W | Slot to free |
| slot_ready_o | output | NUM_SLOTS | Per-slot all-sources-ready |
| reg_ready_o | output | NUM_PREGS | Scoreboard bits |
| wake_count_o | output | CNT_W | Slots woken by this completion |
| cmpl_prod_vld_o | output | 1 | Completed register had a producer |
| cmpl_prod_o | output | SLOT_W | Producer slot of completed register |
| conflict_o | output | 1 | Destination re-produced while waited on |

## Verification
The bench builds the block with 24 physical registers, 5-bit register indices and 8 slots. Indices 24 to 31 therefore fit on every port but lie outside the tracked range, which lets the untracked-index rules be exercised directly. With 8 slots, a single completion can wake two slots at once. The same build also reaches the other corner cases: a squashed slot that drops out of a later wake count, a source that becomes ready through a completion in its own dispatch cycle, and a producer being replaced in the same cycle its register completes.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SRC_N = 2;

  function automatic logic idx_tracked(input int unsigned idx, input int unsigned n_regs);
    return idx < n_regs;
  endfunction
endpackage

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
  parameter int unsigned NUM_PREGS = 24,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmpl_hit_i,
  input  logic [REG_IDX_W-1:0] cmpl_reg_i,
  input  logic                 dst_trk_i,
  input  logic [REG_IDX_W-1:0] dst_reg_i,
  input  logic [SLOT_W-1:0]    dst_slot_i,
  output logic [NUM_PREGS-1:0] ready_o,
  output logic                 cmpl_prod_vld_o,
  output logic [SLOT_W-1:0]    cmpl_prod_o
);
  logic [NUM_PREGS-1:0] ready_q;
  logic [NUM_PREGS-1:0] prod_vld_q;
  logic [SLOT_W-1:0]    prod_q [NUM_PREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q    <= '0;
      prod_vld_q <= '0;
      prod_q     <= '{default: '0};
    end else begin
      for (int r = 0; r < int'(NUM_PREGS); r++) begin
        // dispatch after completion: new producer wins
        if (dst_trk_i && dst_reg_i == REG_IDX_W'(r)) begin
          ready_q[r]    <= 1'b0;
          prod_vld_q[r] <= 1'b1;
          prod_q[r]     <= dst_slot_i;
        end else if (cmpl_hit_i && cmpl_reg_i == REG_IDX_W'(r)) begin
          ready_q[r]    <= 1'b1;
          prod_vld_q[r] <= 1'b0;
        end
      end
    end
  end

  assign ready_o         = ready_q;
  assign cmpl_prod_vld_o = cmpl_hit_i && prod_vld_q[cmpl_reg_i];
  assign cmpl_prod_o     = cmpl_prod_vld_o ? prod_q[cmpl_reg_i] : '0;

  p_cmpl_sets_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_hit_i && !(dst_trk_i && dst_reg_i == cmpl_reg_i)) |=> ready_q[$past(cmpl_reg_i)]);

  p_dst_owned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_trk_i |=> (!ready_q[$past(dst_reg_i)] && prod_vld_q[$past(dst_reg_i)]
                   && prod_q[$past(dst_reg_i)] == $past(dst_slot_i)));
endmodule

// File: rtl/sb_waiter_matrix.sv
module sb_waiter_matrix #(
  parameter int unsigned NUM_PREGS = 24,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned SRC_N  = sb_pkg::SRC_N
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cmpl_hit_i,
  input  logic [REG_IDX_W-1:0]             cmpl_reg_i,
  input  logic [SLOT_W-1:0]                disp_slot_i,
  input  logic [SRC_N-1:0][REG_IDX_W-1:0]  disp_src_i,
  input  logic [SRC_N-1:0]                 disp_wait_i,
  input  logic [SLOT_W-1:0]                sq_slot_i,
  input  logic [SRC_N-1:0][REG_IDX_W-1:0]  sq_src_i,
  input  logic [SRC_N-1:0]                 sq_wait_i,
  input  logic                             dst_trk_i,
  input  logic [REG_IDX_W-1:0]             dst_reg_i,
  output logic [NUM_SLOTS-1:0]             cmpl_row_o,
  output logic                             dst_busy_o,
  output logic [NUM_SLOTS-1:0]             slot_waiting_o
);
  logic [NUM_SLOTS-1:0] wait_q [NUM_PREGS];
  logic [NUM_SLOTS-1:0] wait_d [NUM_PREGS];

  always_comb begin
    wait_d = wait_q;
    for (int r = 0; r < int'(NUM_PREGS); r++) begin
      if (cmpl_hit_i && cmpl_reg_i == REG_IDX_W'(r)) wait_d[r] = '0;
      for (int k = 0; k < int'(SRC_N); k++) begin
        if (sq_wait_i[k] && sq_src_i[k] == REG_IDX_W'(r)) wait_d[r][sq_slot_i] = 1'b0;
      end
      for (int k = 0; k < int'(SRC_N); k++) begin
        if (disp_wait_i[k] && disp_src_i[k] == REG_IDX_W'(r)) wait_d[r][disp_slot_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= '{default: '0};
    else         wait_q <= wait_d;
  end

  assign cmpl_row_o = cmpl_hit_i ? wait_q[cmpl_reg_i] : '0;
  assign dst_busy_o = dst_trk_i && (|wait_q[dst_reg_i])
                      && !(cmpl_hit_i && cmpl_reg_i == dst_reg_i);

  always_comb begin
    slot_waiting_o = '0;
    for (int r = 0; r < int'(NUM_PREGS); r++) slot_waiting_o |= wait_q[r];
  end

  p_row_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_hit_i |=> (wait_q[$past(cmpl_reg_i)] == '0));
endmodule

// File: rtl/sb_slot_state.sv
module sb_slot_state #(
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned SRC_N  = sb_pkg::SRC_N
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             disp_valid_i,
  input  logic [SLOT_W-1:0]                disp_slot_i,
  input  logic [SRC_N-1:0][REG_IDX_W-1:0]  disp_src_i,
  input  logic [SRC_N-1:0]                 disp_rdy_i,
  input  logic [REG_IDX_W-1:0]             cmpl_reg_i,
  input  logic [NUM_SLOTS-1:0]             cmpl_row_i,
  input  logic                             sq_valid_i,
  input  logic [SLOT_W-1:0]                sq_slot_i,
  output logic [SRC_N-1:0][REG_IDX_W-1:0]  sq_src_o,
  output logic [SRC_N-1:0]                 sq_wait_o,
  output logic [NUM_SLOTS-1:0]             slot_ready_o
);
  logic [NUM_SLOTS-1:0]            occ_q;
  logic [SRC_N-1:0][REG_IDX_W-1:0] src_q [NUM_SLOTS];
  logic [SRC_N-1:0]                rdy_q [NUM_SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      src_q <= '{default: '0};
      rdy_q <= '{default: '0};
    end else begin
      for (int s = 0; s < int'(NUM_SLOTS); s++) begin
        if (disp_valid_i && disp_slot_i == SLOT_W'(s)) begin
          occ_q[s] <= 1'b1;
          src_q[s] <= disp_src_i;
          rdy_q[s] <= disp_rdy_i;
        end else if (sq_valid_i && sq_slot_i == SLOT_W'(s)) begin
          occ_q[s] <= 1'b0;
        end else if (cmpl_row_i[s]) begin
          for (int k = 0; k < int'(SRC_N); k++) begin
            if (!rdy_q[s][k] && src_q[s][k] == cmpl_reg_i) rdy_q[s][k] <= 1'b1;
          end
        end
      end
    end
  end

  // unready sources are always tracked ones, so they are the pending waits
  assign sq_src_o = src_q[sq_slot_i];
  always_comb begin
    for (int k = 0; k < int'(SRC_N); k++)
      sq_wait_o[k] = sq_valid_i && occ_q[sq_slot_i] && !rdy_q[sq_slot_i][k];
  end

  always_comb begin
    for (int s = 0; s < int'(NUM_SLOTS); s++)
      slot_ready_o[s] = occ_q[s] && (&rdy_q[s]);
  end

  p_squash_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_valid_i && !(disp_valid_i && disp_slot_i == sq_slot_i))
      |=> !slot_ready_o[$past(sq_slot_i)]);
endmodule

// File: rtl/reg_wakeup_tracker.sv
module reg_wakeup_tracker #(
  parameter int unsigned NUM_PREGS = 24,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
  localparam int unsigned CNT_W  = $clog2(NUM_SLOTS + 1),
  localparam int unsigned SRC_N  = sb_pkg::SRC_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disp_valid_i,
  input  logic [SLOT_W-1:0]    disp_slot_i,
  input  logic                 disp_src0_valid_i,
  input  logic [REG_IDX_W-1:0] disp_src0_i,
  input  logic                 disp_src0_rdy_i,
  input  logic                 disp_src1_valid_i,
  input  logic [REG_IDX_W-1:0] disp_src1_i,
  input  logic                 disp_src1_rdy_i,
  input  logic                 disp_dst_valid_i,
  input  logic [REG_IDX_W-1:0] disp_dst_i,
  input  logic                 cmpl_valid_i,
  input  logic [REG_IDX_W-1:0] cmpl_reg_i,
  input  logic                 squash_valid_i,
  input  logic [SLOT_W-1:0]    squash_slot_i,
  output logic [NUM_SLOTS-1:0] slot_ready_o,
  output logic [NUM_PREGS-1:0] reg_ready_o,
  output logic [CNT_W-1:0]     wake_count_o,
  output logic                 cmpl_prod_vld_o,
  output logic [SLOT_W-1:0]    cmpl_prod_o,
  output logic                 conflict_o
);
  import sb_pkg::idx_tracked;

  initial begin
    assert ((1 << REG_IDX_W) >= NUM_PREGS)
      else $error("REG_IDX_W too small for NUM_PREGS");
  end

  logic [SRC_N-1:0][REG_IDX_W-1:0] disp_src;
  logic [SRC_N-1:0]                src_vld, src_hint, src_wait, src_rdy;
  logic [SRC_N-1:0][REG_IDX_W-1:0] sq_src;
  logic [SRC_N-1:0]                sq_wait;
  logic [NUM_SLOTS-1:0]            cmpl_row, slot_waiting;
  logic                            cmpl_hit, dst_trk;

  assign disp_src = {disp_src1_i, disp_src0_i};
  assign src_vld  = {disp_src1_valid_i, disp_src0_valid_i};
  assign src_hint = {disp_src1_rdy_i, disp_src0_rdy_i};

  assign cmpl_hit = cmpl_valid_i && idx_tracked(32'(cmpl_reg_i), NUM_PREGS);
  assign dst_trk  = disp_valid_i && disp_dst_valid_i && idx_tracked(32'(disp_dst_i), NUM_PREGS);

  // insertion re-check: scoreboard plus same-cycle completion bypass
  always_comb begin
    for (int k = 0; k < int'(SRC_N); k++) begin
      src_wait[k] = disp_valid_i && src_vld[k] && !src_hint[k]
                    && idx_tracked(32'(disp_src[k]), NUM_PREGS)
                    && !reg_ready_o[disp_src[k]]
                    && !(cmpl_hit && cmpl_reg_i == disp_src[k]);
      src_rdy[k]  = !src_wait[k];
    end
  end

  sb_scoreboard #(
    .NUM_PREGS (NUM_PREGS),
    .REG_IDX_W (REG_IDX_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_scoreboard (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmpl_hit_i      (cmpl_hit),
    .cmpl_reg_i      (cmpl_reg_i),
    .dst_trk_i       (dst_trk),
    .dst_reg_i       (disp_dst_i),
    .dst_slot_i      (disp_slot_i),
    .ready_o         (reg_ready_o),
    .cmpl_prod_vld_o (cmpl_prod_vld_o),
    .cmpl_prod_o     (cmpl_prod_o)
  );

  sb_waiter_matrix #(
    .NUM_PREGS (NUM_PREGS),
    .REG_IDX_W (REG_IDX_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_waiters (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmpl_hit_i     (cmpl_hit),
    .cmpl_reg_i     (cmpl_reg_i),
    .disp_slot_i    (disp_slot_i),
    .disp_src_i     (disp_src),
    .disp_wait_i    (src_wait),
    .sq_slot_i      (squash_slot_i),
    .sq_src_i       (sq_src),
    .sq_wait_i      (sq_wait),
    .dst_trk_i      (dst_trk),
    .dst_reg_i      (disp_dst_i),
    .cmpl_row_o     (cmpl_row),
    .dst_busy_o     (conflict_o),
    .slot_waiting_o (slot_waiting)
  );

  sb_slot_state #(
    .REG_IDX_W (REG_IDX_W),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_slots (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .disp_valid_i (disp_valid_i),
    .disp_slot_i  (disp_slot_i),
    .disp_src_i   (disp_src),
    .disp_rdy_i   (src_rdy),
    .cmpl_reg_i   (cmpl_reg_i),
    .cmpl_row_i   (cmpl_row),
    .sq_valid_i   (squash_valid_i),
    .sq_slot_i    (squash_slot_i),
    .sq_src_o     (sq_src),
    .sq_wait_o    (sq_wait),
    .slot_ready_o (slot_ready_o)
  );

  assign wake_count_o = CNT_W'($countones(cmpl_row));

  for (genvar s = 0; s < int'(NUM_SLOTS); s++) begin : g_slot_chk
    p_ready_not_waiting_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_ready_o[s] |-> !slot_waiting[s]);
  end
endmodule

// File: tb/reg_wakeup_tracker_tb_top.sv
module reg_wakeup_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int IW = 5;
  localparam int NS = 8;
  localparam int N_VEC = 18;

  typedef struct packed {
    logic dv; logic [2:0] ds;
    logic s0v; logic [4:0] s0; logic s0h;
    logic s1v; logic [4:0] s1; logic s1h;
    logic tv; logic [4:0] t;
    logic cv; logic [4:0] c;
    logic qv; logic [2:0] q;
    logic [3:0] ew; logic ecf; logic epv; logic [2:0] ep;
    logic [7:0] esr; logic [4:0] kr; logic ekr;
  } vec_t;

  function automatic vec_t mk(int dv, int ds, int s0v, int s0, int s0h, int s1v, int s1,
                              int s1h, int tv, int t, int cv, int c, int qv, int q,
                              int ew, int ecf, int epv, int ep, int esr, int kr, int ekr);
    vec_t v;
    v.dv = 1'(dv);   v.ds = 3'(ds);
    v.s0v = 1'(s0v); v.s0 = 5'(s0); v.s0h = 1'(s0h);
    v.s1v = 1'(s1v); v.s1 = 5'(s1); v.s1h = 1'(s1h);
    v.tv = 1'(tv);   v.t = 5'(t);
    v.cv = 1'(cv);   v.c = 5'(c);
    v.qv = 1'(qv);   v.q = 3'(q);
    v.ew = 4'(ew);   v.ecf = 1'(ecf); v.epv = 1'(epv); v.ep = 3'(ep);
    v.esr = 8'(esr); v.kr = 5'(kr);  v.ekr = 1'(ekr);
    return v;
  endfunction

  localparam vec_t TBL [N_VEC] = '{
    mk(1,0, 1,3,0,  0,0,0,  1,10, 0,0,  0,0, 0,0,0,0, 'h00, 10,0), // R2 R4 wait on r3
    mk(1,1, 1,3,0,  1,4,0,  1,11, 0,0,  0,0, 0,0,0,0, 'h00,  3,0), // R4 two waits
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,3,  0,0, 2,0,0,0, 'h01,  3,1), // R5 R6 wake two
    mk(1,2, 1,3,0,  1,5,1,  1,12, 0,0,  0,0, 0,0,0,0, 'h05, 12,0), // R4 scoreboard+hint
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,10, 0,0, 0,0,1,0, 'h05, 10,1), // R2 producer slot0
    mk(1,3, 1,11,0, 1,12,0, 1,13, 0,0,  0,0, 0,0,0,0, 'h05, 11,0),
    mk(1,4, 0,0,0,  0,0,0,  1,11, 0,0,  0,0, 0,1,0,0, 'h15, 11,0), // R3 conflict
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,4,  0,0, 1,0,0,0, 'h17,  4,1), // R9 slot1 ready
    mk(0,0, 0,0,0,  0,0,0,  0,0,  0,0,  1,3, 0,0,0,0, 'h17, 12,0), // R8 squash slot3
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,12, 0,0, 0,0,1,2, 'h17, 12,1), // R8 count excludes slot3
    mk(1,6, 1,20,0, 0,0,0,  0,0,  0,0,  0,0, 0,0,0,0, 'h17, 20,0),
    mk(1,7, 0,0,0,  0,0,0,  1,20, 1,20, 0,0, 1,0,0,0, 'hD7, 20,0), // R10 R3 ordering
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,20, 0,0, 0,0,1,7, 'hD7, 20,1), // R10 producer slot7
    mk(1,3, 1,27,0, 1,30,0, 1,25, 0,0,  0,0, 0,0,0,0, 'hDF, 20,1), // R7 untracked
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,27, 0,0, 0,0,0,0, 'hDF, 20,1), // R7 untracked completion
    mk(1,0, 1,6,0,  1,7,0,  0,0,  1,6,  0,0, 0,0,0,0, 'hDE,  6,1), // R4 bypass
    mk(0,0, 0,0,0,  0,0,0,  0,0,  1,7,  0,0, 1,0,0,0, 'hDF,  7,1),
    mk(0,0, 0,0,0,  0,0,0,  0,0,  0,0,  1,4, 0,0,0,0, 'hCF, 11,0)  // R8 squash ready slot
  };

  logic clk, rst_n;
  logic dv, s0v, s0h, s1v, s1h, tv, cv, qv;
  logic [2:0] ds, q;
  logic [4:0] s0, s1, t, c;
  logic [NS-1:0] slot_ready;
  logic [NP-1:0] reg_ready;
  logic [3:0] wake_count;
  logic prod_vld, conflict;
  logic [2:0] prod;
  int checks = 0, errors = 0;
  bit done = 0;

  reg_wakeup_tracker #(.NUM_PREGS(NP), .REG_IDX_W(IW), .NUM_SLOTS(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .disp_valid_i(dv), .disp_slot_i(ds),
    .disp_src0_valid_i(s0v), .disp_src0_i(s0), .disp_src0_rdy_i(s0h),
    .disp_src1_valid_i(s1v), .disp_src1_i(s1), .disp_src1_rdy_i(s1h),
    .disp_dst_valid_i(tv), .disp_dst_i(t),
    .cmpl_valid_i(cv), .cmpl_reg_i(c),
    .squash_valid_i(qv), .squash_slot_i(q),
    .slot_ready_o(slot_ready), .reg_ready_o(reg_ready), .wake_count_o(wake_count),
    .cmpl_prod_vld_o(prod_vld), .cmpl_prod_o(prod), .conflict_o(conflict)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    {dv, s0v, s0h, s1v, s1h, tv, cv, qv} = '0;
    {ds, q, s0, s1, t, c} = '0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reg_ready after reset", 32'(reg_ready), 0);
    check("R1 slot_ready after reset", 32'(slot_ready), 0);
    check("R3 conflict idle", 32'(conflict), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      vec_t v;
      v = TBL[i];
      dv = v.dv; ds = v.ds;
      s0v = v.s0v; s0 = v.s0; s0h = v.s0h;
      s1v = v.s1v; s1 = v.s1; s1h = v.s1h;
      tv = v.tv; t = v.t; cv = v.cv; c = v.c; qv = v.qv; q = v.q;
      #1;
      check("R6 wake_count", 32'(wake_count), 32'(v.ew));
      check("R3 conflict", 32'(conflict), 32'(v.ecf));
      check("R2 producer valid", 32'(prod_vld), 32'(v.epv));
      if (v.epv) check("R2 producer slot", 32'(prod), 32'(v.ep));
      @(posedge clk);
      @(negedge clk);
      idle();
      check("R9 slot_ready", 32'(slot_ready), 32'(v.esr));
      check("R5 reg_ready bit", 32'(reg_ready[v.kr]), 32'(v.ekr));
    end

    // R7 out-of-range destination left no trace in the tracked scoreboard bits
    check("R7 untracked regs", 32'(reg_ready[23:20]), 32'h1);

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reg_ready after second reset", 32'(reg_ready), 0);
    check("R1 slot_ready after second reset", 32'(slot_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    finish_run();
  end
endmodule